// File: doc/BRIEF.md
# Frame Phase Order Monitor

This block watches an active-low framed stream link and confirms that every frame moves through its phases in the correct order. A frame opens with a start marker and enters a header phase. An end-of-header marker moves it to a payload phase. An end-of-payload marker moves it to a footer phase, and an end-of-frame marker closes it. Plain data words may repeat inside each of the three in-frame phases. The monitor only counts a cycle as a transfer when both the source-ready and destination-ready lines are low. On any other cycle it keeps its state, whatever the marker lines show.

When a transfer carries a marker that is not the one expected next, the monitor enters a fault state. It also does this for a data word between frames and for a transfer with more than one marker low. It raises a one-cycle error pulse and sets a sticky flag that only reset clears. The fault state lasts exactly one cycle and then falls back to idle. The monitor then waits for a fresh start marker. The current phase is exposed so that surrounding logic can log or act on it. The block is passive: it never drives the link it observes.

Top module: `frm_seq_checker`

## Requirements
- R1: After reset, phase reads 0 (idle), err_pulse is 0 and err_sticky is 0. Asserting rst_n low forces this state at once.
- R2: A transfer is a cycle with src_rdy_n and dst_rdy_n both low. On any other cycle, a non-fault phase is unchanged, whatever the marker inputs show.
- R3: The fault phase (code 4) is always followed by idle on the next cycle, whatever the inputs.
- R4: Phase codes are idle=0, header=1, payload=2, footer=3. A transfer with only the expected marker advances the phase: sof_n in idle gives 1, eoh_n in 1 gives 2, eop_n in 2 gives 3, and eof_n in 3 gives 0.
- R5: A transfer with no marker low keeps phase 1, 2 or 3 unchanged.
- R6: A transfer with one marker low that is not the expected one sends a non-fault phase to fault. This includes sof_n inside a frame. A transfer with no marker low in idle also sends the phase to fault.
- R7: A transfer with two or more marker inputs low sends any non-fault phase to fault.
- R8: err_pulse is high in exactly the cycles in which phase reads 4.
- R9: err_sticky rises together with the first fault and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_rdy_n | input | 1 | Source ready, active low |
| dst_rdy_n | input | 1 | Destination ready, active low |
| sof_n | input | 1 | Start-of-frame marker, active low |
| eoh_n | input | 1 | End-of-header marker, active low |
| eop_n | input | 1 | End-of-payload marker, active low |
| eof_n | input | 1 | End-of-frame marker, active low |
| err_pulse | output | 1 | High for the single cycle spent in the fault phase |
| err_sticky | output | 1 | Set by any fault, cleared only by reset |
| phase | output | 3 | Current phase code (0 idle, 1 header, 2 payload, 3 footer, 4 fault) |

## Verification
Two functions can collide in the same cycle. The first case is the forced return from fault while a transfer is also present. The bench presents a legal start marker during the fault cycle and expects idle, not header, because the return to idle wins. The second case is a transfer that carries the expected marker together with a forbidden one, such as end-of-frame plus start-of-frame in the footer phase. Here the multi-marker rule must take priority over the normal advance, so the bench expects fault rather than idle. The random phase of the bench keeps both cases occurring by weighting multi-marker transfers and back-to-back transfers after a fault.

// File: rtl/frm_seq_pkg.sv
package frm_seq_pkg;

  // number of frame marker lines; bit index gives the marker order
  localparam int unsigned MARK_N  = 4;
  localparam int unsigned PHASE_W = 3;

  localparam int unsigned MK_SOF = 0;
  localparam int unsigned MK_EOH = 1;
  localparam int unsigned MK_EOP = 2;
  localparam int unsigned MK_EOF = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE  = 3'd0,
    PH_HEAD  = 3'd1,
    PH_BODY  = 3'd2,
    PH_TAIL  = 3'd3,
    PH_FAULT = 3'd4
  } phase_e;

  // classification of one cycle on the link
  typedef struct packed {
    logic              xfer;    // both ready lines low
    logic              plain;   // transfer with no marker
    logic              multi;   // transfer with two or more markers
    logic [MARK_N-1:0] single;  // transfer with exactly one marker (one-hot)
  } mark_cls_t;

  // marker that legally closes the given phase
  function automatic logic [MARK_N-1:0] expect_mark(input phase_e p);
    logic [MARK_N-1:0] m;
    m = '0;
    case (p)
      PH_IDLE: m[MK_SOF] = 1'b1;
      PH_HEAD: m[MK_EOH] = 1'b1;
      PH_BODY: m[MK_EOP] = 1'b1;
      PH_TAIL: m[MK_EOF] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // phase entered after the expected marker
  function automatic phase_e advance(input phase_e p);
    phase_e n;
    case (p)
      PH_IDLE: n = PH_HEAD;
      PH_HEAD: n = PH_BODY;
      PH_BODY: n = PH_TAIL;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/frm_rst_sync.sv
module frm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/frm_mark_decode.sv
module frm_mark_decode
  import frm_seq_pkg::*;
(
  input  logic              src_rdy_n,
  input  logic              dst_rdy_n,
  input  logic [MARK_N-1:0] mark_n,
  output mark_cls_t         cls
);

  localparam int unsigned CNT_W = $clog2(MARK_N + 1);

  logic              xfer;
  logic [MARK_N-1:0] act;
  logic [CNT_W-1:0]  act_cnt;

  assign xfer = ~src_rdy_n & ~dst_rdy_n;

  genvar g;
  generate
    for (g = 0; g < MARK_N; g++) begin : g_act
      assign act[g] = ~mark_n[g];
    end
  endgenerate

  always_comb begin
    act_cnt = '0;
    for (int i = 0; i < MARK_N; i++) begin
      act_cnt = act_cnt + {{(CNT_W-1){1'b0}}, act[i]};
    end
  end

  always_comb begin
    cls.xfer   = xfer;
    cls.plain  = xfer && (act_cnt == '0);
    cls.multi  = xfer && (act_cnt > CNT_W'(1));
    cls.single = (xfer && (act_cnt == CNT_W'(1))) ? act : '0;
  end

endmodule

// File: rtl/frm_seq_next.sv
module frm_seq_next
  import frm_seq_pkg::*;
(
  input  phase_e    cur,
  input  mark_cls_t cls,
  output phase_e    nxt
);

  logic [MARK_N-1:0] want;

  assign want = expect_mark(cur);

  always_comb begin
    nxt = cur;
    if (cur == PH_FAULT) begin
      nxt = PH_IDLE;                      // fault lasts one cycle
    end else if (cls.xfer) begin
      if (cls.multi) begin
        nxt = PH_FAULT;                   // overrides a legal advance
      end else if (cls.single == want) begin
        nxt = advance(cur);
      end else if (cls.plain && (cur != PH_IDLE)) begin
        nxt = cur;
      end else begin
        nxt = PH_FAULT;
      end
    end
  end

endmodule

// File: rtl/frm_seq_state.sv
module frm_seq_state
  import frm_seq_pkg::*;
(
  input  logic   clk,
  input  logic   srst_n,
  input  phase_e nxt,
  output phase_e cur,
  output logic   err_pulse,
  output logic   err_sticky
);

  logic state_en;
  logic pulse_en;
  logic sticky_en;
  logic entering_fault;

  assign entering_fault = (nxt == PH_FAULT);
  assign state_en       = (nxt != cur);
  assign pulse_en       = entering_fault ^ err_pulse;
  assign sticky_en      = entering_fault & ~err_sticky;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cur <= PH_IDLE;
    end else if (state_en) begin
      cur <= nxt;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      err_pulse <= 1'b0;
    end else if (pulse_en) begin
      err_pulse <= entering_fault;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      err_sticky <= 1'b0;
    end else if (sticky_en) begin
      err_sticky <= 1'b1;
    end
  end

  AST_FAULT_EXITS: assert property (@(posedge clk) disable iff (!srst_n)
    (cur == PH_FAULT) |=> (cur == PH_IDLE));                           // R3
  AST_PULSE_TRACKS: assert property (@(posedge clk) disable iff (!srst_n)
    err_pulse == (cur == PH_FAULT));                                   // R8
  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!srst_n)
    err_sticky |=> err_sticky);                                        // R9
  AST_STICKY_COVERS: assert property (@(posedge clk) disable iff (!srst_n)
    err_pulse |-> err_sticky);                                         // R9

endmodule

// File: rtl/frm_seq_checker.sv
module frm_seq_checker
  import frm_seq_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_rdy_n,
  input  logic       dst_rdy_n,
  input  logic       sof_n,
  input  logic       eoh_n,
  input  logic       eop_n,
  input  logic       eof_n,
  output logic       err_pulse,
  output logic       err_sticky,
  output logic [2:0] phase
);

  logic              srst_n;
  logic [MARK_N-1:0] mark_n;
  mark_cls_t         cls;
  phase_e            cur;
  phase_e            nxt;

  assign mark_n[MK_SOF] = sof_n;
  assign mark_n[MK_EOH] = eoh_n;
  assign mark_n[MK_EOP] = eop_n;
  assign mark_n[MK_EOF] = eof_n;

  frm_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  frm_mark_decode u_decode (
    .src_rdy_n (src_rdy_n),
    .dst_rdy_n (dst_rdy_n),
    .mark_n    (mark_n),
    .cls       (cls)
  );

  frm_seq_next u_next (
    .cur (cur),
    .cls (cls),
    .nxt (nxt)
  );

  frm_seq_state u_state (
    .clk        (clk),
    .srst_n     (srst_n),
    .nxt        (nxt),
    .cur        (cur),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky)
  );

  assign phase = cur;

  AST_IDLE_CYCLE_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (!cls.xfer && cur != PH_FAULT) |=> $stable(phase));                // R2
  AST_MULTI_TRAPS: assert property (@(posedge clk) disable iff (!srst_n)
    (cls.multi && cur != PH_FAULT) |=> (phase == 3'd4));               // R7
  AST_DATA_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!srst_n)
    (cls.plain && cur == PH_IDLE) |=> (phase == 3'd4));                // R6
  AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({cls.plain, cls.multi, |cls.single}));                    // R7

endmodule

// File: tb/frm_seq_checker_bench.sv
module frm_seq_checker_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       src_rdy_n, dst_rdy_n;
  logic [3:0] act;              // bit0 sof, bit1 eoh, bit2 eop, bit3 eof
  logic       err_pulse, err_sticky;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  int e_ph   = 0;
  bit e_stk  = 0;
  bit done   = 0;

  always #10 clk = ~clk;        // 50 MHz

  frm_seq_checker u_frm_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_rdy_n  (src_rdy_n),
    .dst_rdy_n  (dst_rdy_n),
    .sof_n      (~act[0]),
    .eoh_n      (~act[1]),
    .eop_n      (~act[2]),
    .eof_n      (~act[3]),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky),
    .phase      (phase)
  );

  function automatic int model(input int ph, input bit x, input bit [3:0] m,
                               output string tag);
    int n;
    if (ph == 4) begin tag = "R3"; return 0; end
    if (!x)      begin tag = "R2"; return ph; end
    n = $countones(m);
    if (n > 1) begin tag = "R7"; return 4; end
    if (n == 0) begin
      if (ph == 0) begin tag = "R6"; return 4; end
      tag = "R5"; return ph;
    end
    if (m == (4'b0001 << ph)) begin tag = "R4"; return (ph == 3) ? 0 : ph + 1; end
    tag = "R6";
    return 4;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input bit s_n, input bit d_n, input bit [3:0] m);
    string tag;
    src_rdy_n = s_n;
    dst_rdy_n = d_n;
    act       = m;
    e_ph  = model(e_ph, !s_n && !d_n, m, tag);
    e_stk = e_stk | (e_ph == 4);
    @(posedge clk);
    @(negedge clk);
    check(tag,  int'(phase),      e_ph);
    check("R8", int'(err_pulse),  (e_ph == 4) ? 1 : 0);
    check("R9", int'(err_sticky), e_stk ? 1 : 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R1", int'(phase),      0);
    check("R1", int'(err_pulse),  0);
    check("R1", int'(err_sticky), 0);
    e_ph = 0; e_stk = 0;
    src_rdy_n = 1'b1; dst_rdy_n = 1'b1; act = 4'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", int'(phase),      0);
    check("R1", int'(err_sticky), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [3:0] m;
    int r;
    void'($urandom(32'd4711));
    src_rdy_n = 1'b1; dst_rdy_n = 1'b1; act = 4'b0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // clean frame with repeated words in each phase (R4, R5)
    step(0, 0, 4'b0001); step(0, 0, 4'b0000); step(0, 0, 4'b0010);
    step(0, 0, 4'b0000); step(0, 0, 4'b0000); step(0, 0, 4'b0100);
    step(0, 0, 4'b0000); step(0, 0, 4'b1000);
    // markers without transfer are ignored (R2)
    step(0, 0, 4'b0001);
    step(1, 0, 4'b1001); step(0, 1, 4'b0110); step(1, 1, 4'b1111);
    // second start inside a frame (R6), then start during fault (R3)
    step(0, 0, 4'b0001);
    step(0, 0, 4'b0001);
    // data in idle (R6), then a sticky check without further faults
    step(0, 0, 4'b0000); step(1, 1, 4'b0000);
    // expected marker combined with a forbidden one (R7)
    step(0, 0, 4'b0001); step(0, 0, 4'b0010); step(0, 0, 4'b0100);
    step(0, 0, 4'b1001); step(1, 1, 4'b0000);
    // reset clears the sticky flag (R9, R1)
    do_reset();

    for (int k = 0; k < 4000; k++) begin
      r = $urandom_range(99);
      if (r < 45)      m = 4'b0000;
      else if (r < 80) m = (e_ph < 4) ? (4'b0001 << e_ph) : 4'b0001;
      else if (r < 90) m = 4'b0001 << $urandom_range(3);
      else             m = 4'($urandom_range(15));
      step($urandom_range(99) < 15, $urandom_range(99) < 15, m);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule